// File: doc/BRIEF.md
# PCIe Application Interrupt Status Controller

This block sits next to a PCIe controller core and gathers the core's side-band events into four 32-bit sticky status banks. Two banks capture single-cycle pulse events. A third records every low-to-high transition of its level inputs. The fourth records every high-to-low transition of its level inputs. Each status bank has a matching enable bank. Software clears status bits by writing ones to them. The enabled status bits are combined into one level interrupt for the sub-controller handler. The message-signalled-interrupt event in the rising-edge bank drives its own separate output and does not feed the shared one.

The same register port also holds three things. The first is the link-training enable bit that starts and stops the link. The second is the operating-mode register, which selects root port or endpoint. The third is a read-only view of the link training state, together with a decoded link-up flag. Software drives the register port with a single strobe and a write qualifier. Read data is registered and comes back on the cycle after the read strobe.

Top module: `pcie_irq_agg`

## Requirements
- R1: After reset, every status and enable bit is 0, the training enable, mode register and read data are 0, and `subIrq`, `msiIrq`, `trainEn` and `rootMode` are low.
- R2: A bit of `pulseEvtA` (bank at offset 0x0) or `pulseEvtB` (bank at 0x4) that is high on a clock edge sets the same bit of that status bank on that edge.
- R3: The status bank at 0x8 sets a bit on each 0-to-1 change of the matching `levelRiseIn` bit. An input that stays high does not set the bit again after it has been cleared.
- R4: The status bank at 0xC sets a bit on each 1-to-0 change of the matching `levelFallIn` bit.
- R5: A write to a status bank clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When an event for a bit arrives on the same edge as a write that clears that bit, the bit stays set.
- R7: Enable banks sit at 0x10, 0x14, 0x18 and 0x1C, paired in order with the status banks at 0x0 through 0xC, and read back as written. `subIrq` is high exactly while any status bit is set together with its enable, leaving out bit 17 of the 0x8 bank. It stays high until those bits are cleared.
- R8: `msiIrq` is high exactly while bit 17 of the 0x8 status bank and bit 17 of the 0x18 enable bank are both set.
- R9: Bit 0 of the register at 0x54 drives `trainEn` and reads back. Writing 0 to it drops `trainEn`.
- R10: A read of 0x2C8 returns `ltssmState` in bits 5:0 with zeros above. `linkUp` is high exactly when `ltssmState` equals 0x11.
- R11: The register at 0x80 stores bits 2:0 of the written value and reads them back. `rootMode` is high exactly when the stored value is 4, and a stored 0 selects endpoint.
- R12: Reading an unmapped offset returns 0. Writing to an unmapped offset changes no register and no output.
- R13: `regRdata` takes the addressed value on the edge where `regSel` is high and `regWr` is low. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access strobe, one cycle per access |
| regWr | input | 1 | 1 = write, 0 = read, qualified by regSel |
| regAddr | input | 12 | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| pulseEvtA | input | 32 | Pulse events for the 0x0 bank |
| pulseEvtB | input | 32 | Pulse events for the 0x4 bank |
| levelRiseIn | input | 32 | Level signals whose rising edges feed the 0x8 bank |
| levelFallIn | input | 32 | Level signals whose falling edges feed the 0xC bank |
| ltssmState | input | 6 | Current link training state from the core |
| trainEn | output | 1 | Link training enable |
| rootMode | output | 1 | High when the mode register selects root port |
| linkUp | output | 1 | Link training state equals the link-up code |
| subIrq | output | 1 | Combined level interrupt of the enabled status bits |
| msiIrq | output | 1 | Dedicated MSI-event interrupt |

## Verification
The vector table drives each bank with single bits, with multi-bit groups such as the eight DMA bits and the link-up bits, and with masks that are partly enabled and partly disabled. Each entry tells apart the stored status, which ignores the enable, from the interrupt, which depends on it. The MSI entry separates the dedicated output from the shared one. The falling-bank entries use inputs that rest high, so a design that captures the wrong edge is caught. Directed cases cover a rising input that stays high after being cleared, a clear and an event arriving on the same edge, a clear written with zero bits, the link-up code next to a neighbouring code, a mode value other than the two defined ones, and unmapped accesses.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int NUM_BANKS = 4;
  localparam int MSI_BANK  = 2;

  typedef enum logic [1:0] {
    CAP_PULSE,
    CAP_RISE,
    CAP_FALL
  } capMode_e;

  // capture style chosen per bank index
  function automatic capMode_e bankMode(input int b);
    if (b < 2) return CAP_PULSE;
    else if (b == 2) return CAP_RISE;
    else return CAP_FALL;
  endfunction

  localparam logic [11:0] OFS_TRAIN = 12'h054;
  localparam logic [11:0] OFS_MODE  = 12'h080;
  localparam logic [11:0] OFS_LTSSM = 12'h2C8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_EN,
    RD_TRAIN,
    RD_MODE,
    RD_LTSSM
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0] wrStat;
    logic [NUM_BANKS-1:0] wrEn;
    logic                 wrTrain;
    logic                 wrMode;
    logic                 rdStrobe;
    rdSrc_e               rdSrc;
    logic [1:0]           rdBank;
  } regStrobe_t;

endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam int BANK_SPAN = 5;  // status + enable banks occupy offsets below 0x20

  logic       inBankArea;
  logic       isEnable;
  logic [1:0] bankIdx;
  logic       wrGo;

  assign inBankArea = (regAddr[ADDR_W-1:BANK_SPAN] == '0) && (regAddr[1:0] == 2'b00);
  assign isEnable   = regAddr[4];
  assign bankIdx    = regAddr[3:2];
  assign wrGo       = regSel && regWr;

  always_comb begin
    strobe          = '0;
    strobe.rdStrobe = regSel && !regWr;
    strobe.rdBank   = bankIdx;
    strobe.rdSrc    = RD_NONE;
    if (inBankArea) begin
      strobe.rdSrc = isEnable ? RD_EN : RD_STAT;
      if (isEnable) strobe.wrEn[bankIdx]   = wrGo;
      else          strobe.wrStat[bankIdx] = wrGo;
    end else if (regAddr == ADDR_W'(OFS_TRAIN)) begin
      strobe.rdSrc   = RD_TRAIN;
      strobe.wrTrain = wrGo;
    end else if (regAddr == ADDR_W'(OFS_MODE)) begin
      strobe.rdSrc  = RD_MODE;
      strobe.wrMode = wrGo;
    end else if (regAddr == ADDR_W'(OFS_LTSSM)) begin
      strobe.rdSrc = RD_LTSSM;
    end
  end

endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int STATE_W      = 6,
  parameter int MODE_W       = 3,
  parameter int MSI_BIT      = 17,
  parameter int LINK_UP_CODE = 17,
  parameter int ROOT_CODE    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  pulseA,
  input  logic [DATA_W-1:0]  pulseB,
  input  logic [DATA_W-1:0]  levelRise,
  input  logic [DATA_W-1:0]  levelFall,
  input  logic [STATE_W-1:0] ltssmState,
  output logic [DATA_W-1:0]  rdata,
  output logic               subIrq,
  output logic               msiIrq,
  output logic               trainEn,
  output logic               rootMode,
  output logic               linkUp
);

  logic [DATA_W-1:0] srcIn  [NUM_BANKS];
  logic [DATA_W-1:0] evtNow [NUM_BANKS];
  logic [DATA_W-1:0] statQ  [NUM_BANKS];
  logic [DATA_W-1:0] enQ    [NUM_BANKS];
  logic [DATA_W-1:0] irqPart[NUM_BANKS];
  logic [MODE_W-1:0] modeQ;
  logic [DATA_W-1:0] rdNext;

  assign srcIn[0] = pulseA;
  assign srcIn[1] = pulseB;
  assign srcIn[2] = levelRise;
  assign srcIn[3] = levelFall;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam logic [DATA_W-1:0] EXCL =
      (b == MSI_BANK) ? (DATA_W'(1) << MSI_BIT) : '0;

    if (bankMode(b) == CAP_PULSE) begin : gPulse
      assign evtNow[b] = srcIn[b];
    end else begin : gEdge
      logic [DATA_W-1:0] prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) prevQ <= '0;
        else       prevQ <= srcIn[b];
      end
      if (bankMode(b) == CAP_RISE) begin : gRise
        assign evtNow[b] = srcIn[b] & ~prevQ;
      end else begin : gFall
        assign evtNow[b] = ~srcIn[b] & prevQ;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ[b] <= '0;
        enQ[b]   <= '0;
      end else begin
        // new events override a simultaneous clear
        statQ[b] <= (statQ[b] & ~(strobe.wrStat[b] ? wdata : '0)) | evtNow[b];
        if (strobe.wrEn[b]) enQ[b] <= wdata;
      end
    end

    assign irqPart[b] = statQ[b] & enQ[b] & ~EXCL;

    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrStat[b] && ((evtNow[b] & wdata) == '0))
      |=> ((statQ[b] & $past(wdata)) == '0));

    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (evtNow[b] != '0)
      |=> ((statQ[b] & $past(evtNow[b])) == $past(evtNow[b])));
  end

  always_comb begin
    subIrq = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) subIrq = subIrq | (|irqPart[b]);
  end

  assign msiIrq = statQ[MSI_BANK][MSI_BIT] & enQ[MSI_BANK][MSI_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trainEn <= 1'b0;
      modeQ   <= '0;
    end else begin
      if (strobe.wrTrain) trainEn <= wdata[0];
      if (strobe.wrMode)  modeQ   <= wdata[MODE_W-1:0];
    end
  end

  assign rootMode = (modeQ == MODE_W'(ROOT_CODE));
  assign linkUp   = (ltssmState == STATE_W'(LINK_UP_CODE));

  always_comb begin
    unique case (strobe.rdSrc)
      RD_STAT:  rdNext = statQ[strobe.rdBank];
      RD_EN:    rdNext = enQ[strobe.rdBank];
      RD_TRAIN: rdNext = DATA_W'(trainEn);
      RD_MODE:  rdNext = DATA_W'(modeQ);
      RD_LTSSM: rdNext = DATA_W'(ltssmState);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                rdata <= '0;
    else if (strobe.rdStrobe) rdata <= rdNext;
  end

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subIrq && (strobe.wrStat == '0) && (strobe.wrEn == '0)) |=> subIrq);

  // R9
  train_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrTrain |=> $stable(trainEn));

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdStrobe |=> $stable(rdata));

  // R8
  msi_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!msiIrq && !strobe.wrEn[MSI_BANK] && !evtNow[MSI_BANK][MSI_BIT]) |=> !msiIrq);

endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
  import pirq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 12,
  parameter int STATE_W      = 6,
  parameter int MODE_W       = 3,
  parameter int MSI_BIT      = 17,
  parameter int LINK_UP_CODE = 17,
  parameter int ROOT_CODE    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regSel,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [DATA_W-1:0]  pulseEvtA,
  input  logic [DATA_W-1:0]  pulseEvtB,
  input  logic [DATA_W-1:0]  levelRiseIn,
  input  logic [DATA_W-1:0]  levelFallIn,
  input  logic [STATE_W-1:0] ltssmState,
  output logic               trainEn,
  output logic               rootMode,
  output logic               linkUp,
  output logic               subIrq,
  output logic               msiIrq
);

  regStrobe_t strobe;

  pirq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regSel (regSel),
    .regWr  (regWr),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  pirq_datapath #(
    .DATA_W      (DATA_W),
    .STATE_W     (STATE_W),
    .MODE_W      (MODE_W),
    .MSI_BIT     (MSI_BIT),
    .LINK_UP_CODE(LINK_UP_CODE),
    .ROOT_CODE   (ROOT_CODE)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (regWdata),
    .pulseA    (pulseEvtA),
    .pulseB    (pulseEvtB),
    .levelRise (levelRiseIn),
    .levelFall (levelFallIn),
    .ltssmState(ltssmState),
    .rdata     (regRdata),
    .subIrq    (subIrq),
    .msiIrq    (msiIrq),
    .trainEn   (trainEn),
    .rootMode  (rootMode),
    .linkUp    (linkUp)
  );

endmodule

// File: tb/pcie_irq_agg_test.sv
module pcie_irq_agg_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] pulseEvtA = '0;
  logic [31:0] pulseEvtB = '0;
  logic [31:0] levelRiseIn = '0;
  logic [31:0] levelFallIn = '1;
  logic [5:0]  ltssmState = '0;
  logic        trainEn, rootMode, linkUp, subIrq, msiIrq;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pcie_irq_agg uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pulseEvtA(pulseEvtA),
    .pulseEvtB(pulseEvtB), .levelRiseIn(levelRiseIn), .levelFallIn(levelFallIn),
    .ltssmState(ltssmState), .trainEn(trainEn), .rootMode(rootMode),
    .linkUp(linkUp), .subIrq(subIrq), .msiIrq(msiIrq)
  );

  // {bank[1:0], event mask[31:0], enable mask[31:0]}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {2'd0, 32'h0000_0001, 32'h0000_0001},
    {2'd0, 32'h8000_0000, 32'h0000_0000},
    {2'd1, 32'h0000_0005, 32'h0000_0004},
    {2'd2, 32'h0000_3FC0, 32'h0000_0040},
    {2'd2, 32'h0002_0000, 32'h0002_0000},
    {2'd2, 32'h2400_0000, 32'hFFFF_FFFF},
    {2'd3, 32'h0000_000F, 32'h0000_0008},
    {2'd3, 32'h0000_0002, 32'h0000_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    @(negedge clk);
    regSel = 1'b0;
    d = regRdata;
  endtask

  // one-cycle event on a bank; returns at the negedge after capture
  task automatic inject(input int bank, input logic [31:0] m);
    @(negedge clk);
    case (bank)
      0: pulseEvtA = m;
      1: pulseEvtB = m;
      2: levelRiseIn = m;
      default: levelFallIn = ~m;
    endcase
    @(negedge clk);
    pulseEvtA = '0; pulseEvtB = '0; levelRiseIn = '0; levelFallIn = '1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      nBad++; nChecks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 subIrq", 32'(subIrq), 0);
    chk("R1 msiIrq", 32'(msiIrq), 0);
    chk("R1 trainEn", 32'(trainEn), 0);
    chk("R1 rootMode", 32'(rootMode), 0);
    chk("R1 rdata", regRdata, 0);
    for (int a = 0; a < 8; a++) begin
      rd(12'(a * 4), d);
      chk("R1 bank reg", d, 0);
    end
    rd(12'h054, d); chk("R1 train reg", d, 0);
    rd(12'h080, d); chk("R1 mode reg", d, 0);

    // table walk: R2 R3 R4 R7 R8
    for (int i = 0; i < NV; i++) begin
      int          bank;
      logic [31:0] ev, en, excl;
      bank = int'(VEC[i][65:64]);
      ev   = VEC[i][63:32];
      en   = VEC[i][31:0];
      excl = (bank == 2) ? 32'h0002_0000 : 32'h0;
      wr(12'h010 + 12'(bank * 4), en);
      rd(12'h010 + 12'(bank * 4), d);
      chk("R7 enable readback", d, en);
      inject(bank, ev);
      chk("R7 subIrq", 32'(subIrq), 32'(|(ev & en & ~excl)));
      chk("R8 msiIrq", 32'(msiIrq), 32'((bank == 2) && ev[17] && en[17]));
      rd(12'(bank * 4), d);
      chk(bank < 2 ? "R2 pulse status" : (bank == 2 ? "R3 rise status" : "R4 fall status"), d, ev);
      wr(12'(bank * 4), ev);
      rd(12'(bank * 4), d);
      chk("R5 cleared", d, 0);
      chk("R7 subIrq after clear", 32'(subIrq), 0);
      chk("R8 msiIrq after clear", 32'(msiIrq), 0);
      wr(12'h010 + 12'(bank * 4), 32'h0);
    end

    // R7 level holds until cleared
    wr(12'h000, 32'h0); wr(12'h010, 32'h10);
    inject(0, 32'h10);
    repeat (5) @(negedge clk);
    chk("R7 subIrq held", 32'(subIrq), 1);
    wr(12'h000, 32'h10);
    chk("R7 subIrq dropped", 32'(subIrq), 0);
    wr(12'h010, 32'h0);

    // R5 write 0 leaves bits
    inject(1, 32'h3);
    wr(12'h004, 32'h1);
    rd(12'h004, d); chk("R5 partial clear", d, 32'h2);
    wr(12'h004, 32'h0);
    rd(12'h004, d); chk("R5 zero write keeps", d, 32'h2);
    wr(12'h004, 32'h2);

    // R6 event and clear on the same edge
    inject(0, 32'h8);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; regAddr = 12'h000; regWdata = 32'h8;
    pulseEvtA = 32'h8;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; pulseEvtA = '0;
    rd(12'h000, d); chk("R6 event wins", d, 32'h8);
    wr(12'h000, 32'h8);

    // R3 steady high does not re-set
    @(negedge clk); levelRiseIn = 32'h40;
    @(negedge clk);
    wr(12'h008, 32'h40);
    repeat (4) @(negedge clk);
    rd(12'h008, d); chk("R3 steady high no reset", d, 0);
    levelRiseIn = '0;

    // R4 rising on fall bank is not captured
    @(negedge clk); levelFallIn = 32'hFFFF_FFFE;
    @(negedge clk);
    wr(12'h00C, 32'h1);
    levelFallIn = '1;
    repeat (2) @(negedge clk);
    rd(12'h00C, d); chk("R4 rise ignored", d, 0);

    // R9 training enable
    wr(12'h054, 32'h1);
    chk("R9 trainEn set", 32'(trainEn), 1);
    rd(12'h054, d); chk("R9 readback", d, 1);
    wr(12'h054, 32'h0);
    chk("R9 trainEn cleared", 32'(trainEn), 0);

    // R10 link state
    ltssmState = 6'h11;
    @(negedge clk);
    chk("R10 linkUp at 0x11", 32'(linkUp), 1);
    rd(12'h2C8, d); chk("R10 state read", d, 32'h11);
    ltssmState = 6'h10;
    @(negedge clk);
    chk("R10 linkUp at 0x10", 32'(linkUp), 0);
    ltssmState = 6'h3F;
    rd(12'h2C8, d); chk("R10 state read 3F", d, 32'h3F);

    // R13 read data holds without a read strobe
    ltssmState = 6'h05;
    repeat (3) @(negedge clk);
    chk("R13 rdata hold", regRdata, 32'h3F);

    // R11 mode register
    wr(12'h080, 32'h4);
    chk("R11 root", 32'(rootMode), 1);
    rd(12'h080, d); chk("R11 readback 4", d, 4);
    wr(12'h080, 32'h5);
    chk("R11 value 5 not root", 32'(rootMode), 0);
    rd(12'h080, d); chk("R11 readback 5", d, 5);
    wr(12'h080, 32'h0);
    chk("R11 endpoint", 32'(rootMode), 0);

    // R12 unmapped accesses
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h2C4, 32'hFFFF_FFFF);
    wr(12'h056, 32'hFFFF_FFFF);
    chk("R12 trainEn untouched", 32'(trainEn), 0);
    chk("R12 rootMode untouched", 32'(rootMode), 0);
    chk("R12 subIrq untouched", 32'(subIrq), 0);
    for (int a = 0; a < 8; a++) begin
      rd(12'(a * 4), d);
      chk("R12 bank untouched", d, 0);
    end
    rd(12'h040, d); chk("R12 unmapped read", d, 0);
    rd(12'h2C4, d); chk("R12 unmapped read 2C4", d, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule